// File: doc/BRIEF.md
# Function Event Report Queue

This block holds pending function events in arrival order and hands them to a host one at a time as formatted response records. An event is either an error event (class 1) or an availability event (class 2). Each entry carries its class, a 16-bit status code, a 32-bit function handle, a 32-bit function ID, a 64-bit fault address and a 32-bit error qualifier. Every event that enters the queue raises a one-cycle notification toward the host.

Events come from two sources. A direct producer port accepts error and availability events. An internal plug sequencer expands a hot-plug or unplug request into a fixed series of availability events. When the host pops, the oldest entry is turned into a big-endian byte record. The record carries its own length, and its layout depends on the event class.

Top module: `fevq_top`

## Requirements
- R1: Events leave the queue in the order they were stored. Each pop returns the oldest stored entry.
- R2: A class-1 record is 26 bytes, with byte 0 the most significant byte of `rec_data`. The layout is: bytes 0-1 length (26), byte 2 class, byte 3 zero, bytes 4-7 function ID, bytes 8-11 handle, bytes 12-15 qualifier, bytes 16-23 fault address, bytes 24-25 status. All fields are big-endian.
- R3: A class-2 record has length 14. The layout is: bytes 0-1 length, byte 2 class, byte 3 zero, bytes 4-7 function ID, bytes 8-11 handle, bytes 12-13 status. Bytes 14-25 are zero.
- R4: `rec_valid` is high for exactly the cycle after a cycle with `pop` high, and `rec_data` holds the record during that cycle. `have_event` is high exactly when the queue holds at least one entry.
- R5: Each event stored in the queue produces a one-cycle `notify` pulse in the cycle after it is stored.
- R6: A hot-plug request enqueues two availability events for the given handle and ID, in this order: status 0x0301, then status 0x0302. `hp_busy` is high from the cycle after the request until the last event is stored.
- R7: An unplug request with `hp_configured` high enqueues status 0x0304 and then status 0x0308. With `hp_configured` low it enqueues only 0x0308.
- R8: The queue holds DEPTH entries (8 by default). A push while the queue is full is dropped, even if a pop happens in the same cycle. A dropped push sets `overflow`, which stays set until reset.
- R9: A pop on an empty queue returns a record with class 0, length 4 and all other bytes zero.
- R10: A direct push whose class is neither 1 nor 2 is ignored. Nothing is stored and no notification is raised.
- R11: When a direct push and a sequencer event are ready in the same cycle, the direct push is stored first. The sequencer holds its event until a later cycle.
- R12: After reset, `have_event`, `overflow`, `notify`, `rec_valid` and `hp_busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_push | input | 1 | Direct producer push strobe |
| ev_class | input | 2 | Event class: 1 for error, 2 for availability |
| ev_status | input | 16 | Status code |
| ev_handle | input | 32 | Function handle |
| ev_fid | input | 32 | Function ID |
| ev_addr | input | 64 | Fault address |
| ev_qual | input | 32 | Error qualifier |
| hp_plug | input | 1 | Hot-plug request pulse |
| hp_unplug | input | 1 | Unplug request pulse |
| hp_configured | input | 1 | The function is configured at the time of the unplug |
| hp_handle | input | 32 | Handle used for plug and unplug events |
| hp_fid | input | 32 | Function ID used for plug and unplug events |
| hp_busy | output | 1 | Plug sequencer still emitting events |
| notify | output | 1 | Pulse for each stored event |
| have_event | output | 1 | Queue is not empty |
| overflow | output | 1 | Sticky flag set when a push is dropped |
| pop | input | 1 | Consumer pop strobe |
| rec_valid | output | 1 | Response record valid |
| rec_data | output | 208 | Big-endian response record, byte 0 in the top bits |

## Verification
The bench builds the block with its default depth of 8. At that depth, the bench fills the queue completely and pushes a ninth event to drive the drop-and-flag path. It then drains the queue to confirm that the eighth entry, not the ninth, comes out last. The shallow depth also brings a plug request that collides with a direct push within reach, and the bench checks that pop order exposes the arbitration.

// File: rtl/fevq_pkg.sv
package fevq_pkg;

    localparam int FID_W     = 32;
    localparam int FH_W      = 32;
    localparam int QUAL_W    = 32;
    localparam int ADDR_W    = 64;
    localparam int STAT_W    = 16;
    localparam int REC_BYTES = 26;
    localparam int REC_W     = REC_BYTES * 8;

    localparam int LEN_ERR   = 26;
    localparam int LEN_AVAIL = 14;
    localparam int LEN_NONE  = 4;

    localparam logic [STAT_W-1:0] ST_RES_TO_STBY = 16'h0301;
    localparam logic [STAT_W-1:0] ST_STBY_TO_CFG = 16'h0302;
    localparam logic [STAT_W-1:0] ST_CFG_TO_STBY = 16'h0304;
    localparam logic [STAT_W-1:0] ST_STBY_TO_RES = 16'h0308;

    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_ERR   = 2'd1,
        CL_AVAIL = 2'd2,
        CL_RSVD  = 2'd3
    } fev_class_e;

    typedef struct packed {
        fev_class_e          cls;
        logic [STAT_W-1:0]   status;
        logic [FH_W-1:0]     handle;
        logic [FID_W-1:0]    fid;
        logic [ADDR_W-1:0]   addr;
        logic [QUAL_W-1:0]   qual;
    } fev_t;

    typedef logic [0:REC_BYTES-1][7:0] fev_rec_t;

    function automatic logic class_ok(input logic [1:0] c);
        return (c == CL_ERR) || (c == CL_AVAIL);
    endfunction

endpackage

// File: rtl/fevq_fifo.sv
module fevq_fifo
    import fevq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  fev_t wr_data,
    input  logic rd_en,
    output fev_t rd_data,
    output logic empty,
    output logic full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    fev_t             mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             wr_ok, rd_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= step(wp);
            if (rd_ok) rp <= step(rp);
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/fevq_seq.sv
module fevq_seq
    import fevq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             plug_req,
    input  logic             unplug_req,
    input  logic             was_cfg,
    input  logic [FH_W-1:0]  handle,
    input  logic [FID_W-1:0] fid,
    input  logic             grant,
    output logic             out_valid,
    output fev_t             out_ev,
    output logic             busy
);
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PLUG_A, SQ_PLUG_B, SQ_UNPL_A, SQ_UNPL_B
    } sq_state_e;

    sq_state_e        state;
    logic [FH_W-1:0]  h_q;
    logic [FID_W-1:0] f_q;
    logic [STAT_W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            h_q   <= '0;
            f_q   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (plug_req) begin
                        state <= SQ_PLUG_A;
                        h_q   <= handle;
                        f_q   <= fid;
                    end else if (unplug_req) begin
                        state <= was_cfg ? SQ_UNPL_A : SQ_UNPL_B;
                        h_q   <= handle;
                        f_q   <= fid;
                    end
                end
                SQ_PLUG_A: if (grant) state <= SQ_PLUG_B;
                SQ_PLUG_B: if (grant) state <= SQ_IDLE;
                SQ_UNPL_A: if (grant) state <= SQ_UNPL_B;
                SQ_UNPL_B: if (grant) state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            SQ_PLUG_A: st = ST_RES_TO_STBY;
            SQ_PLUG_B: st = ST_STBY_TO_CFG;
            SQ_UNPL_A: st = ST_CFG_TO_STBY;
            SQ_UNPL_B: st = ST_STBY_TO_RES;
            default:   st = '0;
        endcase
    end

    assign busy      = (state != SQ_IDLE);
    assign out_valid = busy;
    assign out_ev    = '{cls: CL_AVAIL, status: st, handle: h_q, fid: f_q,
                         addr: '0, qual: '0};
endmodule

// File: rtl/fevq_fmt.sv
module fevq_fmt
    import fevq_pkg::*;
(
    input  fev_t     ent,
    input  logic     ent_valid,
    output fev_rec_t rec
);
    always_comb begin
        rec = '0;
        if (!ent_valid) begin
            rec[0:1] = 16'(LEN_NONE);
        end else begin
            rec[2]    = {6'd0, ent.cls};
            rec[4:7]  = ent.fid;
            rec[8:11] = ent.handle;
            if (ent.cls == CL_ERR) begin
                rec[0:1]   = 16'(LEN_ERR);
                rec[12:15] = ent.qual;
                rec[16:23] = ent.addr;
                rec[24:25] = ent.status;
            end else begin
                rec[0:1]   = 16'(LEN_AVAIL);
                rec[12:13] = ent.status;
            end
        end
    end
endmodule

// File: rtl/fevq_top.sv
module fevq_top
    import fevq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_push,
    input  logic [1:0]        ev_class,
    input  logic [STAT_W-1:0] ev_status,
    input  logic [FH_W-1:0]   ev_handle,
    input  logic [FID_W-1:0]  ev_fid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [QUAL_W-1:0] ev_qual,
    input  logic              hp_plug,
    input  logic              hp_unplug,
    input  logic              hp_configured,
    input  logic [FH_W-1:0]   hp_handle,
    input  logic [FID_W-1:0]  hp_fid,
    output logic              hp_busy,
    output logic              notify,
    output logic              have_event,
    output logic              overflow,
    input  logic              pop,
    output logic              rec_valid,
    output logic [REC_W-1:0]  rec_data
);
    logic     direct_ok, seq_valid, seq_grant, wr_en, q_empty, q_full;
    fev_t     direct_ev, seq_ev, wr_ev, head_ev;
    fev_rec_t fmt_rec;
    logic     notify_q, ovf_q, rv_q;
    logic [REC_W-1:0] rec_q;

    assign direct_ok = ev_push && class_ok(ev_class);
    assign direct_ev = '{cls: fev_class_e'(ev_class), status: ev_status,
                         handle: ev_handle, fid: ev_fid, addr: ev_addr,
                         qual: ev_qual};
    assign seq_grant = seq_valid && !direct_ok;
    assign wr_en     = direct_ok || seq_valid;
    assign wr_ev     = direct_ok ? direct_ev : seq_ev;

    fevq_seq seq_i (
        .clk(clk), .rst(rst), .plug_req(hp_plug), .unplug_req(hp_unplug),
        .was_cfg(hp_configured), .handle(hp_handle), .fid(hp_fid),
        .grant(seq_grant), .out_valid(seq_valid), .out_ev(seq_ev),
        .busy(hp_busy)
    );

    fevq_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_ev),
        .rd_en(pop), .rd_data(head_ev), .empty(q_empty), .full(q_full)
    );

    fevq_fmt fmt_i (.ent(head_ev), .ent_valid(!q_empty), .rec(fmt_rec));

    always_ff @(posedge clk) begin
        if (rst) begin
            notify_q <= 1'b0;
            ovf_q    <= 1'b0;
            rv_q     <= 1'b0;
            rec_q    <= '0;
        end else begin
            notify_q <= wr_en && !q_full;
            ovf_q    <= ovf_q || (wr_en && q_full);
            rv_q     <= pop;
            if (pop) rec_q <= fmt_rec;
        end
    end

    assign notify     = notify_q;
    assign overflow   = ovf_q;
    assign rec_valid  = rv_q;
    assign rec_data   = rec_q;
    assign have_event = !q_empty;
endmodule

// File: rtl/fevq_chk.sv
module fevq_chk
    import fevq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hp_plug,
    input logic             hp_busy,
    input logic             notify,
    input logic             have_event,
    input logic             overflow,
    input logic             pop,
    input logic             rec_valid,
    input logic [REC_W-1:0] rec_data
);
    p_rec_after_pop_r4: assert property (@(posedge clk) disable iff (rst)
        pop |=> rec_valid);

    p_no_rec_without_pop_r4: assert property (@(posedge clk) disable iff (rst)
        !pop |=> !rec_valid);

    p_notify_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        notify |-> have_event);

    p_plug_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (hp_plug && !hp_busy) |=> hp_busy);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && !have_event) |=> (rec_data[REC_W-17 -: 8] == 8'd0));
endmodule

bind fevq_top fevq_chk chk_i (.*);

// File: tb/fevq_tb.sv
`timescale 1ns/1ps
module fevq_top_tb_top;
    import fevq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_push = 1'b0;
    logic [1:0] ev_class = '0;
    logic [15:0] ev_status = '0;
    logic [31:0] ev_handle = '0, ev_fid = '0, ev_qual = '0;
    logic [63:0] ev_addr = '0;
    logic hp_plug = 1'b0, hp_unplug = 1'b0, hp_configured = 1'b0;
    logic [31:0] hp_handle = '0, hp_fid = '0;
    logic hp_busy, notify, have_event, overflow, pop = 1'b0, rec_valid;
    logic [207:0] rec_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    fevq_top dut_i (.*);

    localparam fev_t VEC [4] = '{
        '{CL_ERR,   16'h00A1, 32'h1111_2222, 32'h0000_0003, 64'h0123_4567_89AB_CDEF, 32'hDEAD_BEEF},
        '{CL_AVAIL, 16'h0042, 32'h8000_0007, 32'h0000_0007, 64'h0,                   32'h0},
        '{CL_ERR,   16'hFFFF, 32'hA5A5_5A5A, 32'hFFFF_FFFF, 64'hFFFF_0000_FFFF_0000, 32'h0000_0001},
        '{CL_AVAIL, 16'h0001, 32'h0000_0001, 32'h8000_0000, 64'h0,                   32'h0}
    };

    function automatic logic [207:0] exp_rec(input logic [1:0] c, input logic [15:0] s,
        input logic [31:0] h, input logic [31:0] f, input logic [63:0] a, input logic [31:0] q);
        logic [7:0] b [26];
        logic [207:0] r;
        for (int i = 0; i < 26; i++) b[i] = 8'h00;
        b[2] = {6'd0, c};
        if (c == 2'd0) begin
            b[1] = 8'd4;
        end else begin
            for (int i = 0; i < 4; i++) begin
                b[4 + i] = f[31 - 8*i -: 8];
                b[8 + i] = h[31 - 8*i -: 8];
            end
            if (c == 2'd1) begin
                b[1] = 8'd26;
                for (int i = 0; i < 4; i++) b[12 + i] = q[31 - 8*i -: 8];
                for (int i = 0; i < 8; i++) b[16 + i] = a[63 - 8*i -: 8];
                b[24] = s[15:8];
                b[25] = s[7:0];
            end else begin
                b[1] = 8'd14;
                b[12] = s[15:8];
                b[13] = s[7:0];
            end
        end
        for (int i = 0; i < 26; i++) r[207 - 8*i -: 8] = b[i];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [207:0] act,
                       input logic [207:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_ev(input fev_t e);
        @(negedge clk);
        ev_push = 1'b1; ev_class = e.cls; ev_status = e.status;
        ev_handle = e.handle; ev_fid = e.fid; ev_addr = e.addr; ev_qual = e.qual;
        @(negedge clk);
        ev_push = 1'b0;
    endtask

    task automatic pop_chk(input logic [207:0] exp, input string req);
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk(rec_valid === 1'b1 && rec_data === exp, req, rec_data, exp);
    endtask

    task automatic hp_req(input logic plug, input logic cfg, input logic [31:0] h,
                          input logic [31:0] f);
        @(negedge clk);
        hp_plug = plug; hp_unplug = !plug; hp_configured = cfg;
        hp_handle = h; hp_fid = f;
        @(negedge clk);
        hp_plug = 1'b0; hp_unplug = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        fev_t e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk({have_event, overflow, notify, rec_valid, hp_busy} === 5'b0, "R12",
            208'({have_event, overflow, notify, rec_valid, hp_busy}), 208'd0);

        // table walk: R1 order, R2/R3 layouts, R5 notify
        for (int i = 0; i < 4; i++) begin
            push_ev(VEC[i]);
            chk(notify === 1'b1, "R5 notify after push", 208'(notify), 208'd1);
        end
        @(negedge clk);
        chk(notify === 1'b0, "R5 single pulse", 208'(notify), 208'd0);
        chk(have_event === 1'b1, "R4 have_event set", 208'(have_event), 208'd1);
        for (int i = 0; i < 4; i++) begin
            pop_chk(exp_rec(VEC[i].cls, VEC[i].status, VEC[i].handle, VEC[i].fid,
                            VEC[i].addr, VEC[i].qual),
                    VEC[i].cls == CL_ERR ? "R1 R2 error record" : "R1 R3 avail record");
        end
        chk(have_event === 1'b0, "R4 have_event clear", 208'(have_event), 208'd0);

        // R10 invalid class ignored
        e = '{CL_RSVD, 16'h1234, 32'h1, 32'h2, 64'h3, 32'h4};
        push_ev(e);
        chk(notify === 1'b0 && have_event === 1'b0, "R10",
            208'({notify, have_event}), 208'd0);
        e = '{CL_NONE, 16'h1234, 32'h1, 32'h2, 64'h3, 32'h4};
        push_ev(e);
        chk(notify === 1'b0 && have_event === 1'b0, "R10 class0",
            208'({notify, have_event}), 208'd0);

        // R9 pop on empty
        pop_chk(exp_rec(2'd0, 16'h0, 32'h0, 32'h0, 64'h0, 32'h0), "R9 empty pop");

        // R6 plug sequence
        hp_req(1'b1, 1'b0, 32'h8000_0005, 32'h0000_0005);
        chk(hp_busy === 1'b1, "R6 busy", 208'(hp_busy), 208'd1);
        repeat (3) @(negedge clk);
        chk(hp_busy === 1'b0, "R6 idle", 208'(hp_busy), 208'd0);
        pop_chk(exp_rec(2'd2, 16'h0301, 32'h8000_0005, 32'h5, 64'h0, 32'h0), "R6 first");
        pop_chk(exp_rec(2'd2, 16'h0302, 32'h8000_0005, 32'h5, 64'h0, 32'h0), "R6 second");
        chk(have_event === 1'b0, "R6 only two", 208'(have_event), 208'd0);

        // R7 unplug configured and unconfigured
        hp_req(1'b0, 1'b1, 32'h8000_0009, 32'h9);
        repeat (3) @(negedge clk);
        hp_req(1'b0, 1'b0, 32'h8000_000A, 32'hA);
        repeat (3) @(negedge clk);
        pop_chk(exp_rec(2'd2, 16'h0304, 32'h8000_0009, 32'h9, 64'h0, 32'h0), "R7 cfg first");
        pop_chk(exp_rec(2'd2, 16'h0308, 32'h8000_0009, 32'h9, 64'h0, 32'h0), "R7 cfg second");
        pop_chk(exp_rec(2'd2, 16'h0308, 32'h8000_000A, 32'hA, 64'h0, 32'h0), "R7 uncfg");
        chk(have_event === 1'b0, "R7 uncfg single", 208'(have_event), 208'd0);

        // R11 direct push wins over sequencer
        @(negedge clk);
        hp_plug = 1'b1; hp_handle = 32'h8000_000B; hp_fid = 32'hB;
        @(negedge clk);
        hp_plug = 1'b0;
        ev_push = 1'b1; ev_class = 2'd1; ev_status = 16'h0077; ev_handle = 32'hC;
        ev_fid = 32'hD; ev_addr = 64'hE; ev_qual = 32'hF;
        @(negedge clk);
        ev_push = 1'b0;
        repeat (3) @(negedge clk);
        pop_chk(exp_rec(2'd1, 16'h0077, 32'hC, 32'hD, 64'hE, 32'hF), "R11 direct first");
        pop_chk(exp_rec(2'd2, 16'h0301, 32'h8000_000B, 32'hB, 64'h0, 32'h0), "R11 seq next");
        pop_chk(exp_rec(2'd2, 16'h0302, 32'h8000_000B, 32'hB, 64'h0, 32'h0), "R11 seq last");

        // R8 overflow at depth 8
        for (int i = 0; i < 8; i++) begin
            e = '{CL_AVAIL, 16'(i + 16'h0100), 32'(i), 32'(i + 100), 64'h0, 32'h0};
            push_ev(e);
        end
        chk(overflow === 1'b0, "R8 no overflow when exactly full", 208'(overflow), 208'd0);
        e = '{CL_AVAIL, 16'h0999, 32'h99, 32'h99, 64'h0, 32'h0};
        push_ev(e);
        chk(overflow === 1'b1 && notify === 1'b0, "R8 drop sets overflow",
            208'({overflow, notify}), 208'b10);
        for (int i = 0; i < 8; i++) begin
            pop_chk(exp_rec(2'd2, 16'(i + 16'h0100), 32'(i), 32'(i + 100), 64'h0, 32'h0),
                    "R8 drain");
        end
        chk(have_event === 1'b0 && overflow === 1'b1, "R8 dropped entry absent, sticky",
            208'({have_event, overflow}), 208'b01);
        do_reset();
        @(negedge clk);
        chk(overflow === 1'b0, "R12 reset clears overflow", 208'(overflow), 208'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule